// File: doc/BRIEF.md
# Privilege-Qualified Interrupt Selector

This block decides, within a single cycle, whether a hart should take an interrupt and which cause number it should take. It first masks the pending interrupt lines with their per-line enables. Each surviving line is then routed to one of two handling levels by its delegation bit. A line with the bit clear is handled at machine level. A line with the bit set is handled at supervisor level.

Each level has its own global permission. That permission comes from the current privilege and from that level's global interrupt-enable status bit. A line that passes every gate is a qualifying interrupt. When more than one line qualifies, the lowest-numbered one wins.

The block has no state. The trap logic of a core samples its outputs directly, and the outputs follow the inputs in the same cycle.

Top module: `irq_select`

## Requirements
- R1: A line is a candidate only when both its pending bit and its enable bit are 1. A line whose enable bit is 0 is never reported as the cause, whatever its pending bit.
- R2: When the current privilege is user (code 0) or supervisor (code 1), machine-handled lines (delegation bit 0) qualify even when `m_gie` is 0.
- R3: At machine privilege (code 3), a machine-handled line qualifies only when `m_gie` is 1.
- R4: At user privilege, supervisor-handled lines (delegation bit 1) qualify even when `s_gie` is 0.
- R5: At supervisor privilege, a supervisor-handled line qualifies only when `s_gie` is 1.
- R6: At machine privilege, a supervisor-handled line never qualifies, whatever `s_gie` is.
- R7: When several lines qualify, `irq_cause` is the index of the lowest-numbered qualifying line, as an unsigned binary number.
- R8: When no line qualifies, `take_irq` is 0 and `irq_cause` is 0.
- R9: Privilege code 2 behaves exactly like user privilege (code 0).
- R10: Both outputs settle within the same cycle as the inputs that produce them. The block keeps no state between cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| irq_pend | input | 16 | Pending interrupt lines, one bit per cause |
| irq_en | input | 16 | Per-line interrupt enables |
| irq_deleg | input | 16 | 1 = line handled at supervisor level, 0 = machine level |
| m_gie | input | 1 | Machine-level global interrupt enable status bit |
| s_gie | input | 1 | Supervisor-level global interrupt enable status bit |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| take_irq | output | 1 | An interrupt qualifies and should be taken now |
| irq_cause | output | 4 | Index of the winning line, 0 when none qualifies |

## Verification
Every result of this block is due in the same cycle as the stimulus that produces it, because no register lies between the inputs and the outputs. The bench therefore applies each input vector on a rising edge and compares both outputs on the falling edge of that same cycle. The comparison is against a behavioural model of the enable and priority rules. A single cycle that both drives a vector and checks the result also shows that no earlier vector leaves any residue in the outputs. The vectors include directed cases for each privilege and enable combination, plus a few thousand random vectors.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

    localparam int unsigned NUM_LINES = 16;
    localparam int unsigned CAUSE_W   = $clog2(NUM_LINES);

    typedef enum logic [1:0] {
        LVL_USER  = 2'd0,
        LVL_SUPER = 2'd1,
        LVL_RSVD  = 2'd2,
        LVL_MACH  = 2'd3
    } priv_lvl_e;

    typedef struct packed {
        logic m_open;
        logic s_open;
    } gate_pair_t;

    // Reserved code folds onto user level.
    function automatic priv_lvl_e fold_priv(input logic [1:0] code);
        priv_lvl_e p;
        p = priv_lvl_e'(code);
        if (p == LVL_RSVD) p = LVL_USER;
        return p;
    endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_select_pkg::*;
(
    input  logic [1:0] cur_priv,
    input  logic       m_gie,
    input  logic       s_gie,
    output gate_pair_t gates
);
    priv_lvl_e lvl;

    always_comb begin
        lvl = fold_priv(cur_priv);
        gates.m_open = (lvl != LVL_MACH) || m_gie;
        gates.s_open = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_gie);
    end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_select_pkg::*;
#(
    parameter int unsigned N = NUM_LINES
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] en,
    input  logic [N-1:0] deleg,
    input  gate_pair_t   gates,
    output logic [N-1:0] ready
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign ready[i] = pend[i] & en[i] & (deleg[i] ? gates.s_open : gates.m_open);
    end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int unsigned N  = 16,
    parameter int unsigned CW = $clog2(N)
) (
    input  logic [N-1:0]  ready,
    output logic          any,
    output logic [CW-1:0] idx
);
    logic [N-1:0] lowest;

    // Isolate least-significant set bit.
    assign lowest = ready & (~ready + N'(1));
    assign any    = |ready;

    for (genvar b = 0; b < CW; b++) begin : g_bit
        logic [N-1:0] sel;
        for (genvar i = 0; i < N; i++) begin : g_src
            assign sel[i] = lowest[i] & ((i >> b) & 1) != 0;
        end
        assign idx[b] = |sel;
    end
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_select_pkg::*;
(
    input  logic [NUM_LINES-1:0] irq_pend,
    input  logic [NUM_LINES-1:0] irq_en,
    input  logic [NUM_LINES-1:0] irq_deleg,
    input  logic                 m_gie,
    input  logic                 s_gie,
    input  logic [1:0]           cur_priv,
    output logic                 take_irq,
    output logic [CAUSE_W-1:0]   irq_cause
);
    gate_pair_t           gates;
    logic [NUM_LINES-1:0] ready;

    irq_level_gate u_gate (
        .cur_priv (cur_priv),
        .m_gie    (m_gie),
        .s_gie    (s_gie),
        .gates    (gates)
    );

    irq_qualify #(.N(NUM_LINES)) u_qual (
        .pend  (irq_pend),
        .en    (irq_en),
        .deleg (irq_deleg),
        .gates (gates),
        .ready (ready)
    );

    irq_lowest_pick #(.N(NUM_LINES), .CW(CAUSE_W)) u_pick (
        .ready (ready),
        .any   (take_irq),
        .idx   (irq_cause)
    );
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk
    import irq_select_pkg::*;
(
    input logic [NUM_LINES-1:0] irq_pend,
    input logic [NUM_LINES-1:0] irq_en,
    input logic [NUM_LINES-1:0] irq_deleg,
    input logic                 m_gie,
    input logic                 s_gie,
    input logic [1:0]           cur_priv,
    input logic                 take_irq,
    input logic [CAUSE_W-1:0]   irq_cause
);
    always_comb begin
        if (take_irq) begin
            p_cause_live_r1: assert (irq_pend[irq_cause] && irq_en[irq_cause]);
            p_mach_mask_r3: assert (!(cur_priv == 2'd3 && !irq_deleg[irq_cause]) || m_gie);
            p_super_mask_r5: assert (!(cur_priv == 2'd1 && irq_deleg[irq_cause]) || s_gie);
            p_no_deleg_in_m_r6: assert (!(cur_priv == 2'd3 && irq_deleg[irq_cause]));
        end else begin
            p_idle_zero_r8: assert (irq_cause == '0);
        end
        p_none_pending_r8: assert (|(irq_pend & irq_en) || !take_irq);
    end
endmodule

bind irq_select irq_select_chk i_chk (
    .irq_pend  (irq_pend),
    .irq_en    (irq_en),
    .irq_deleg (irq_deleg),
    .m_gie     (m_gie),
    .s_gie     (s_gie),
    .cur_priv  (cur_priv),
    .take_irq  (take_irq),
    .irq_cause (irq_cause)
);

// File: tb/test_irq_select.sv
module test_irq_select;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pend = '0, en = '0, deleg = '0;
    logic        mg = 1'b0, sg = 1'b0;
    logic [1:0]  pv = 2'd0;
    logic        take;
    logic [3:0]  cause;
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    irq_select i_irq_select (
        .irq_pend (pend), .irq_en (en), .irq_deleg (deleg),
        .m_gie (mg), .s_gie (sg), .cur_priv (pv),
        .take_irq (take), .irq_cause (cause)
    );

    // Behavioural model of the rules.
    function automatic int model(input logic [15:0] p, input logic [15:0] e,
                                 input logic [15:0] d, input logic m, input logic s,
                                 input logic [1:0] lv);
        bit m_ok, s_ok;
        int l;
        l = (lv == 2) ? 0 : int'(lv);
        m_ok = (l < 3) || m;
        s_ok = (l == 0) || (l == 1 && s);
        for (int i = 0; i < 16; i++)
            if (p[i] && e[i] && (d[i] ? s_ok : m_ok)) return i;
        return -1;
    endfunction

    task automatic apply(input string tag, input logic [15:0] p, input logic [15:0] e,
                         input logic [15:0] d, input logic m, input logic s,
                         input logic [1:0] lv);
        int exp_c;
        @(posedge clk);
        pend <= p; en <= e; deleg <= d; mg <= m; sg <= s; pv <= lv;
        @(negedge clk); // same cycle: no register on the path (R10)
        exp_c = model(p, e, d, m, s, lv);
        n_vec++;
        if (take !== (exp_c >= 0) || cause !== ((exp_c >= 0) ? 4'(exp_c) : 4'd0)) begin
            n_bad++;
            $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                     tag, take, cause, exp_c >= 0, (exp_c >= 0) ? exp_c : 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        apply("R8 idle",          16'h0000, 16'hFFFF, 16'h0000, 1, 1, 2'd3);
        apply("R1 not enabled",   16'h00F0, 16'h000F, 16'h0000, 1, 1, 2'd0);
        apply("R1 enabled subset",16'h00F0, 16'h0020, 16'h0000, 1, 1, 2'd0);
        apply("R2 user no mie",   16'h0100, 16'hFFFF, 16'h0000, 0, 0, 2'd0);
        apply("R2 super no mie",  16'h0100, 16'hFFFF, 16'h0000, 0, 0, 2'd1);
        apply("R3 mach mie off",  16'h0100, 16'hFFFF, 16'h0000, 0, 1, 2'd3);
        apply("R3 mach mie on",   16'h0100, 16'hFFFF, 16'h0000, 1, 0, 2'd3);
        apply("R4 user no sie",   16'h0040, 16'hFFFF, 16'h0040, 0, 0, 2'd0);
        apply("R5 super sie off", 16'h0040, 16'hFFFF, 16'h0040, 1, 0, 2'd1);
        apply("R5 super sie on",  16'h0040, 16'hFFFF, 16'h0040, 0, 1, 2'd1);
        apply("R6 mach deleg",    16'h0040, 16'hFFFF, 16'h0040, 1, 1, 2'd3);
        apply("R6 mach mixed",    16'h0041, 16'hFFFF, 16'h0001, 1, 1, 2'd3);
        apply("R7 lowest",        16'hA0A0, 16'hFFFF, 16'h0000, 1, 1, 2'd0);
        apply("R7 top bit",       16'h8000, 16'hFFFF, 16'h0000, 1, 1, 2'd3);
        apply("R7 bit0",          16'hFFFF, 16'hFFFF, 16'h0000, 1, 1, 2'd3);
        apply("R9 code2 deleg",   16'h0040, 16'hFFFF, 16'h0040, 0, 0, 2'd2);
        apply("R9 code2 mach",    16'h0200, 16'hFFFF, 16'h0000, 0, 0, 2'd2);
        apply("R10 back to idle", 16'h0000, 16'h0000, 16'h0000, 0, 0, 2'd3);
        for (int k = 0; k < 4000; k++)
            apply("R7 random", 16'($urandom), 16'($urandom), 16'($urandom),
                  1'($urandom), 1'($urandom), 2'($urandom));
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: done=0 expected done=1");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule